// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table and the register port through which software fills it. Each entry has one 8-bit red, one 8-bit green and one 8-bit blue value, kept in three separate per-channel arrays. A display pipeline presents an 8-bit pixel code on the lookup port and gets that entry's three colour values back combinationally, in the same cycle.

Software reaches the table through a 16-byte window on a simple valid/ready register bus. Only full 32-bit accesses are accepted. A write to the pointer register selects an entry and restarts the colour sequence. Three writes to the colour register then fill in red, green and blue for that entry, in that order. After the third write the pointer moves on to the next entry, so a whole table can be streamed in with one pointer write followed by a run of colour writes. Every value, whether a pointer or a colour, is carried in the most significant byte of the bus word. Reads return zero and have no effect.

Top module: `clut_loader`

## Requirements
- R1: After reset, every entry reads (0,0,0) on the lookup port except entry 255, which reads (255,255,255). The pointer is 0 and the colour sequence starts at red.
- R2: A write to byte offset 0 (the pointer register) loads bits 31:24 of the write data into the pointer and returns the colour sequence to red, even partway through an entry.
- R3: Writes to byte offset 4 (the colour register) store bits 31:24 of the write data into red, then green, then blue of the entry the pointer selects. Bits 23:0 are ignored.
- R4: The third colour write (blue) advances the pointer by one modulo 256, so 255 goes to 0, and returns the sequence to red. Red and green writes leave the pointer unchanged.
- R5: A colour value written in a handshake cycle shows on the lookup port, for that entry, from the following clock cycle onward.
- R6: Writes to byte offsets 8 and 12, and writes whose address has bits 1:0 not equal to 00, change neither the table, the pointer nor the colour sequence.
- R7: A write whose byte enables are not all four set (4'b1111) is ignored in the same way as R6.
- R8: A read in the window returns zero on bus_rdata and does not advance the colour sequence or the pointer.
- R9: bus_ready is high in every cycle in which bus_valid is high, so every access completes in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data; the value sits in bits 31:24 |
| bus_ready | output | 1 | Access acknowledge |
| bus_rdata | output | 32 | Read data, always zero |
| lut_idx | input | 8 | Lookup entry select |
| lut_red | output | 8 | Red value of the selected entry |
| lut_green | output | 8 | Green value of the selected entry |
| lut_blue | output | 8 | Blue value of the selected entry |

## Verification
The bench goes after the wrap of the pointer from 255 to 0 after a blue write. A design that saturated the pointer, or advanced it after red or green, would put colours into the wrong entries. A pointer write in the middle of an entry is issued so that a sequencer that failed to restart at red would shift every later colour by one channel. Reads, partial byte enables, misaligned addresses and the two unused offsets are mixed into random traffic. A decoder that let any of them through would corrupt an entry or skew the sequence, and the next lookup comparison exposes it. The reset contents are scanned entry by entry, so a white entry placed at the wrong end of the table is caught.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int unsigned CH_W    = 8;
  localparam int unsigned N_CHAN  = 3;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;

  // Value carried in the most significant byte of a bus word
  function automatic logic [CH_W-1:0] top_byte(input logic [31:0] word);
    return word[31 -: CH_W];
  endfunction

  // Colour sequence step: red -> green -> blue -> red
  function automatic comp_e comp_after(input comp_e c);
    case (c)
      COMP_RED:   return COMP_GREEN;
      COMP_GREEN: return COMP_BLUE;
      default:    return COMP_RED;
    endcase
  endfunction

  // Reset level of an entry: only the last entry is full scale
  function automatic logic [CH_W-1:0] reset_level(input int unsigned entry,
                                                  input int unsigned depth);
    return (entry == depth - 1) ? {CH_W{1'b1}} : '0;
  endfunction

endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned PTR_OFS  = 0,
  parameter int unsigned DATA_OFS = 4
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  output logic              bus_ready,
  output logic              ptr_wr,
  output logic              col_wr
);
  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] PTR_WA  = WA_W'(PTR_OFS >> 2);
  localparam logic [WA_W-1:0] DATA_WA = WA_W'(DATA_OFS >> 2);

  logic word_ok;
  logic [WA_W-1:0] wa;

  assign wa        = bus_addr[ADDR_W-1:2];
  assign word_ok   = bus_valid && bus_write && (bus_be == 4'hF) &&
                     (bus_addr[1:0] == 2'b00);
  assign bus_ready = bus_valid;
  assign ptr_wr    = word_ok && (wa == PTR_WA);
  assign col_wr    = word_ok && (wa == DATA_WA);
endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic             col_wr,
  input  logic [CH_W-1:0]  wr_val,
  output logic [IDX_W-1:0] cur_idx,
  output comp_e            cur_comp,
  output logic             entry_done
);
  assign entry_done = col_wr && (cur_comp == COMP_BLUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_comp <= COMP_RED;
    end else if (ptr_wr) begin
      cur_idx  <= wr_val[CH_W-1 -: IDX_W];
      cur_comp <= COMP_RED;
    end else if (col_wr) begin
      cur_comp <= comp_after(cur_comp);
      if (entry_done) cur_idx <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/clut_channel.sv
module clut_channel
  import clut_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CH_W-1:0]  wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CH_W-1:0]  rd_val
);
  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem[i] <= reset_level(i, DEPTH);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned PTR_OFS  = 0,
  parameter int unsigned DATA_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        lut_idx,
  output logic [7:0]        lut_red,
  output logic [7:0]        lut_green,
  output logic [7:0]        lut_blue
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  // Named internal events for the checker
  logic             ptr_wr_ev;
  logic             col_wr_ev;
  logic             entry_done_ev;
  logic [CH_W-1:0]  wr_val;
  logic [IDX_W-1:0] cur_idx;
  comp_e            cur_comp;
  logic [CH_W-1:0]  chan_rd [N_CHAN];

  assign wr_val    = top_byte(bus_wdata);
  assign bus_rdata = '0;

  clut_bus_decode #(
    .ADDR_W(ADDR_W), .PTR_OFS(PTR_OFS), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_ready(bus_ready),
    .ptr_wr(ptr_wr_ev), .col_wr(col_wr_ev)
  );

  clut_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr_ev), .col_wr(col_wr_ev),
    .wr_val(wr_val), .cur_idx(cur_idx), .cur_comp(cur_comp),
    .entry_done(entry_done_ev)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    logic sel;
    assign sel = col_wr_ev && (cur_comp == comp_e'(c));
    clut_channel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(sel), .wr_idx(cur_idx),
      .wr_val(wr_val), .rd_idx(lut_idx[IDX_W-1:0]), .rd_val(chan_rd[c])
    );
  end

  assign lut_red   = chan_rd[0];
  assign lut_green = chan_rd[1];
  assign lut_blue  = chan_rd[2];
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        bus_ready,
  input logic [31:0] bus_rdata,
  input logic [7:0]  lut_idx,
  input logic [7:0]  lut_red,
  input logic        ptr_wr_ev,
  input logic        col_wr_ev,
  input logic [7:0]  cur_idx,
  input logic [1:0]  cur_comp
);
  assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_ready);

  assert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (bus_rdata == 32'd0));

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_ev |=> (cur_idx == $past(bus_wdata[31:24])) && (cur_comp == 2'd0));

  assert_seq_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr_ev && cur_comp != 2'd2) |=>
      (cur_comp == $past(cur_comp) + 2'd1) && $stable(cur_idx));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr_ev && cur_comp == 2'd2) |=>
      (cur_comp == 2'd0) && (cur_idx == $past(cur_idx) + 8'd1));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_wr_ev || col_wr_ev) |=> $stable(cur_idx) && $stable(cur_comp));

  assert_partial_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != 4'hF) |-> !(ptr_wr_ev || col_wr_ev));

  assert_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr_ev && cur_comp == 2'd0) ##1 (lut_idx == $past(cur_idx)) |->
      (lut_red == $past(bus_wdata[31:24])));
endmodule

bind clut_loader clut_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_red(lut_red),
  .ptr_wr_ev(ptr_wr_ev), .col_wr_ev(col_wr_ev), .cur_idx(cur_idx),
  .cur_comp(cur_comp)
);

// File: tb/sim_clut_loader.sv
module sim_clut_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_idx = '0;
  logic [7:0]  lut_red, lut_green, lut_blue;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Reference table and sequencer state
  logic [7:0] ref_r [256];
  logic [7:0] ref_g [256];
  logic [7:0] ref_b [256];
  logic [7:0] ref_ptr;
  int         ref_comp;

  always #2 clk = ~clk;

  clut_loader u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .lut_idx(lut_idx),
    .lut_red(lut_red), .lut_green(lut_green), .lut_blue(lut_blue)
  );

  function automatic logic [23:0] pack_rgb(input logic [7:0] r, g, b);
    return {r, g, b};
  endfunction

  // The accepted colour write: only full-word, aligned, offset 4
  function automatic bit is_colour_write(input logic [3:0] a, input logic [3:0] be);
    return (a == 4'd4) && (be == 4'hF);
  endfunction

  function automatic bit is_pointer_write(input logic [3:0] a, input logic [3:0] be);
    return (a == 4'd0) && (be == 4'hF);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_entry(input logic [7:0] i, input string req);
    lut_idx = i;
    #1;
    check(pack_rgb(lut_red, lut_green, lut_blue) ==
          pack_rgb(ref_r[i], ref_g[i], ref_b[i]), req,
          {8'd0, lut_red, lut_green, lut_blue},
          {8'd0, ref_r[i], ref_g[i], ref_b[i]});
  endtask

  // One bus access driven from the falling edge; the model updates after the rising edge
  task automatic access(input bit wr, input logic [3:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    #1;
    check(bus_ready == 1'b1, "R9", {31'd0, bus_ready}, 32'd1);
    if (!wr) check(bus_rdata == 32'd0, "R8", bus_rdata, 32'd0);
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
    if (wr && is_pointer_write(a, be)) begin
      ref_ptr = d[31:24]; ref_comp = 0;
    end else if (wr && is_colour_write(a, be)) begin
      case (ref_comp)
        0: ref_r[ref_ptr] = d[31:24];
        1: ref_g[ref_ptr] = d[31:24];
        default: ref_b[ref_ptr] = d[31:24];
      endcase
      if (ref_comp == 2) begin ref_ptr = ref_ptr + 8'd1; ref_comp = 0; end
      else ref_comp++;
    end
  endtask

  task automatic load_entry(input logic [7:0] i, input logic [23:0] rgb);
    access(1'b1, 4'd0, 4'hF, {i, 24'h5A5A5A});
    access(1'b1, 4'd4, 4'hF, {rgb[23:16], 24'hFFFFFF});
    access(1'b1, 4'd4, 4'hF, {rgb[15:8], 24'h000000});
    access(1'b1, 4'd4, 4'hF, {rgb[7:0], 24'h123456});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      ref_r[i] = (i == 255) ? 8'hFF : 8'h00;
      ref_g[i] = ref_r[i];
      ref_b[i] = ref_r[i];
    end
    ref_ptr = 8'd0; ref_comp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 256; i++) check_entry(8'(i), "R1");
    // R1: pointer starts at 0, sequence at red
    access(1'b1, 4'd4, 4'hF, 32'h11000000);
    check_entry(8'd0, "R1 start red at entry 0");

    // R3, R5: ordered loading, low bits ignored
    load_entry(8'd10, 24'hC0FFEE);
    check_entry(8'd10, "R3 R5");

    // R4: wrap from 255 to 0
    load_entry(8'd255, 24'h102030);
    access(1'b1, 4'd4, 4'hF, 32'h77000000);
    check_entry(8'd255, "R4");
    check_entry(8'd0, "R4 wrap to 0");

    // R2: pointer rewrite mid-entry restarts at red
    access(1'b1, 4'd0, 4'hF, 32'h20000000);
    access(1'b1, 4'd4, 4'hF, 32'hAA000000);
    access(1'b1, 4'd0, 4'hF, 32'h21000000);
    access(1'b1, 4'd4, 4'hF, 32'hBB000000);
    check_entry(8'd20, "R2");
    check_entry(8'd21, "R2 restart red");

    // R6, R7, R8: ignored accesses, then continue the sequence
    access(1'b1, 4'd8,  4'hF, 32'h99000000);
    access(1'b1, 4'd12, 4'hF, 32'h98000000);
    access(1'b1, 4'd5,  4'hF, 32'h97000000);
    access(1'b1, 4'd1,  4'hF, 32'h96000000);
    access(1'b1, 4'd4,  4'h8, 32'h95000000);
    access(1'b1, 4'd0,  4'h7, 32'h94000000);
    access(1'b0, 4'd4,  4'hF, 32'h93000000);
    access(1'b1, 4'd4,  4'hF, 32'hCC000000);
    check_entry(8'd21, "R6 R7 R8 green follows");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      d  = $urandom;
      case (op)
        0, 1:          access(1'b1, 4'd0, 4'hF, d);
        2, 3, 4, 5, 6: access(1'b1, 4'd4, 4'hF, d);
        7:             access(1'b1, 4'(4'd8 + 4'($urandom_range(0, 7))), 4'hF, d);
        8:             access(1'b1, 4'd4, 4'($urandom_range(0, 14)), d);
        default:       access(1'b0, 4'($urandom_range(0, 15)), 4'hF, d);
      endcase
      check_entry(ref_ptr, "R3 R4 R6 R7 R8 random");
      check_entry(8'($urandom_range(0, 255)), "R5 random");
    end

    for (int i = 0; i < 256; i++) check_entry(8'(i), "R3 final scan");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule